// File: doc/BRIEF.md
# Bit-Band Alias Bridge

This block sits between a requester and a backing memory and presents a 32 MB alias window in which every 32-bit alias word stands for exactly one bit of the backing memory. The requester issues alias reads and writes of 1, 2 or 4 bytes on the slave port. The bridge converts each one into an access of the same size on the master port. The master-side address is the configured base combined with the alias offset shifted down by five, and then aligned down to the access size.

A read hands back the one selected bit in bit 0 of the response. The other response bits are zero. A write is carried out as an internal read followed by a write-back of the full unit, with only the selected bit forced to the requested value. An error from the backing memory ends the operation at once and is reported to the requester. The bridge handles one request at a time. A chip normally instantiates it twice, each with its own base parameter: one instance for the SRAM region and one for the peripheral region.

Top module: `bitband_bridge`

## Requirements
- R1: After reset, sReady is 1 and sDone and mReq are 0.
- R2: The master address is (BASE | (sAddr >> 5)) with its low bits cleared to a multiple of the access size. mSize equals sSize, where 0 means 1 byte, 1 means 2 bytes and 2 means 4 bytes.
- R3: A read completes with sRdata holding only the selected bit, in bit 0. The bit index is (sAddr >> 2) AND (8 × bytes − 1), counted over the fetched unit assembled little-endian, so mRdata[7:0] is the lowest address.
- R4: A write first reads the unit, then writes it back to the same address with the same size. The written data equals the fetched data with the selected bit set when sWbit is 1 and cleared when sWbit is 0. All other bytes and bits of backing memory stay unchanged.
- R5: If the backing read returns mErr, the bridge issues no write-back. It completes with sErr=1 and sRdata=0.
- R6: If the write-back returns mErr, the bridge completes with sErr=1. A write that completes without error returns sRdata=0.
- R7: A request is accepted only when sValid and sReady are both 1. sReady stays 0 from acceptance until completion, and a request presented while busy has no effect on backing memory.
- R8: While mReq is 1 and mAck is 0, mReq stays 1 and mAddr, mSize and mWrite hold their values.
- R9: Each accepted request yields exactly one single-cycle sDone pulse, and sReady returns to 1 in the cycle after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| sValid | input | 1 | Alias request present |
| sReady | output | 1 | Bridge idle and able to accept |
| sWrite | input | 1 | 1 for an alias write, 0 for a read |
| sAddr | input | OFF_W (25) | Byte offset inside the alias window |
| sSize | input | 2 | Access size: 0=1 byte, 1=2 bytes, 2=4 bytes |
| sWbit | input | 1 | Value written to the selected bit |
| sDone | output | 1 | One-cycle completion pulse |
| sRdata | output | DATA_W (32) | Read result, selected bit in bit 0 |
| sErr | output | 1 | Error status, valid with sDone |
| mReq | output | 1 | Backing access request, held until mAck |
| mWrite | output | 1 | Backing access is a write |
| mAddr | output | ADDR_W (32) | Backing byte address, size-aligned |
| mSize | output | 2 | Backing access size, same encoding as sSize |
| mWdata | output | DATA_W (32) | Write-back data, little-endian, unused lanes zero |
| mAck | input | 1 | Backing access complete |
| mRdata | input | DATA_W (32) | Backing read data, valid with mAck |
| mErr | input | 1 | Backing access failed, valid with mAck |

## Verification
The hardest condition to reach from the ports is an error that arrives partway through the internal read-modify-write. One case is a failing read inside a write, where the write-back must be suppressed. The other is a failing write-back after a clean read. The bench memory model takes separate per-operation flags that inject an error on the read acknowledge or on the write acknowledge, and it adds a programmable latency so that each phase can be stretched. A second stimulus thread presents a conflicting write while the bridge is busy; the check that it is ignored is made by comparing the whole backing memory with the reference copy.

// File: rtl/bitband_pkg.sv
package bitband_pkg;

  // Access size encoding shared by both ports
  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2
  } accSize_e;

  // Sequencer states
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_READ  = 2'd1,
    ST_WRITE = 2'd2,
    ST_DONE  = 2'd3
  } bbState_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic capture;        // latch a new request
    logic latchRead;      // latch backing read data and status
    logic latchWriteErr;  // latch write-back status
  } dpStrobe_t;

endpackage

// File: rtl/bitband_ctrl.sv
module bitband_ctrl
  import bitband_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      sValid,
  input  logic      isWrite,
  input  logic      mAck,
  input  logic      mErr,
  output logic      sReady,
  output logic      sDone,
  output logic      mReq,
  output logic      mWrite,
  output dpStrobe_t strobe
);

  bbState_e stateQ, stateD;

  always_comb begin
    stateD = stateQ;
    unique case (stateQ)
      ST_IDLE:  if (sValid) stateD = ST_READ;
      ST_READ:  if (mAck) stateD = (mErr || !isWrite) ? ST_DONE : ST_WRITE;
      ST_WRITE: if (mAck) stateD = ST_DONE;
      ST_DONE:  stateD = ST_IDLE;
      default:  stateD = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) stateQ <= ST_IDLE;
    else       stateQ <= stateD;
  end

  always_comb begin
    sReady = (stateQ == ST_IDLE);
    sDone  = (stateQ == ST_DONE);
    mReq   = (stateQ == ST_READ) || (stateQ == ST_WRITE);
    mWrite = (stateQ == ST_WRITE);
    strobe.capture       = (stateQ == ST_IDLE) && sValid;
    strobe.latchRead     = (stateQ == ST_READ) && mAck;
    strobe.latchWriteErr = (stateQ == ST_WRITE) && mAck;
  end

endmodule

// File: rtl/bitband_dp.sv
module bitband_dp
  import bitband_pkg::*;
#(
  parameter int              ADDR_W = 32,
  parameter int              DATA_W = 32,
  parameter int              OFF_W  = 25,
  parameter logic [ADDR_W-1:0] BASE = 32'h2000_0000
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strobe,
  input  logic [OFF_W-1:0]  reqOff,
  input  logic [1:0]        reqSize,
  input  logic              reqWrite,
  input  logic              reqBit,
  input  logic [DATA_W-1:0] mRdata,
  input  logic              mErr,
  output logic [ADDR_W-1:0] mAddr,
  output logic [1:0]        mSize,
  output logic [DATA_W-1:0] mWdata,
  output logic [DATA_W-1:0] sRdata,
  output logic              sErr,
  output logic              isWrite
);

  localparam int LANES  = DATA_W / 8;
  localparam int IDX_W  = $clog2(DATA_W);
  localparam int LANE_W = (LANES > 1) ? $clog2(LANES) : 1;

  logic [OFF_W-1:0]  offQ;
  logic [1:0]        sizeQ;
  logic              wrQ, bitQ, errQ;
  logic [DATA_W-1:0] bufQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      offQ  <= '0;
      sizeQ <= '0;
      wrQ   <= 1'b0;
      bitQ  <= 1'b0;
      errQ  <= 1'b0;
      bufQ  <= '0;
    end else begin
      if (strobe.capture) begin
        offQ  <= reqOff;
        sizeQ <= reqSize;
        wrQ   <= reqWrite;
        bitQ  <= reqBit;
        errQ  <= 1'b0;
      end
      if (strobe.latchRead) begin
        bufQ <= mRdata;
        errQ <= mErr;
      end
      if (strobe.latchWriteErr) errQ <= mErr;
    end
  end

  // Address translation and size alignment
  logic [ADDR_W-1:0] byteMask;
  logic [IDX_W-1:0]  bitMask, bitIdx;
  logic [LANE_W-1:0] laneSel;
  logic [2:0]        bitSel;

  always_comb begin
    byteMask = ADDR_W'((32'd1 << sizeQ) - 32'd1);
    bitMask  = IDX_W'((32'd8 << sizeQ) - 32'd1);
    bitIdx   = offQ[IDX_W+1:2] & bitMask;
    laneSel  = LANE_W'(bitIdx >> 3);
    bitSel   = bitIdx[2:0];
    mAddr    = (BASE | ADDR_W'(offQ >> 5)) & ~byteMask;
    mSize    = sizeQ;
  end

  // Per-lane merge of the selected bit
  for (genvar g = 0; g < LANES; g++) begin : gLane
    logic [7:0] oldByte, newByte;
    logic       laneOn;
    always_comb begin
      oldByte = bufQ[8*g +: 8];
      laneOn  = (32'(g) < (32'd1 << sizeQ));
      newByte = oldByte;
      if (laneSel == LANE_W'(g)) newByte[bitSel] = bitQ;
      mWdata[8*g +: 8] = laneOn ? newByte : 8'h00;
    end
  end

  assign sRdata  = DATA_W'((!wrQ && !errQ) ? bufQ[bitIdx] : 1'b0);
  assign sErr    = errQ;
  assign isWrite = wrQ;

endmodule

// File: rtl/bitband_bridge.sv
module bitband_bridge
  import bitband_pkg::*;
#(
  parameter int                ADDR_W       = 32,
  parameter int                DATA_W       = 32,
  parameter int                WINDOW_BYTES = 32'h0200_0000,
  parameter logic [ADDR_W-1:0] BASE         = 32'h2000_0000,
  localparam int               OFF_W        = $clog2(WINDOW_BYTES)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sValid,
  output logic              sReady,
  input  logic              sWrite,
  input  logic [OFF_W-1:0]  sAddr,
  input  logic [1:0]        sSize,
  input  logic              sWbit,
  output logic              sDone,
  output logic [DATA_W-1:0] sRdata,
  output logic              sErr,
  output logic              mReq,
  output logic              mWrite,
  output logic [ADDR_W-1:0] mAddr,
  output logic [1:0]        mSize,
  output logic [DATA_W-1:0] mWdata,
  input  logic              mAck,
  input  logic [DATA_W-1:0] mRdata,
  input  logic              mErr
);

  dpStrobe_t strobe;
  logic      isWrite;

  bitband_ctrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .sValid  (sValid),
    .isWrite (isWrite),
    .mAck    (mAck),
    .mErr    (mErr),
    .sReady  (sReady),
    .sDone   (sDone),
    .mReq    (mReq),
    .mWrite  (mWrite),
    .strobe  (strobe)
  );

  bitband_dp #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .OFF_W  (OFF_W),
    .BASE   (BASE)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .reqOff   (sAddr),
    .reqSize  (sSize),
    .reqWrite (sWrite),
    .reqBit   (sWbit),
    .mRdata   (mRdata),
    .mErr     (mErr),
    .mAddr    (mAddr),
    .mSize    (mSize),
    .mWdata   (mWdata),
    .sRdata   (sRdata),
    .sErr     (sErr),
    .isWrite  (isWrite)
  );

endmodule

// File: rtl/bitband_bridge_chk.sv
module bitband_bridge_chk #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              sValid,
  input logic              sReady,
  input logic              sDone,
  input logic              sErr,
  input logic              mReq,
  input logic              mWrite,
  input logic [ADDR_W-1:0] mAddr,
  input logic [1:0]        mSize,
  input logic              mAck,
  input logic              mErr
);

  // R1: idle outputs right after reset
  a_r1_reset_idle: assert property (@(posedge clk)
    !rstN |=> (sReady && !sDone && !mReq));

  // R2: backing address aligned to the access size
  a_r2_aligned: assert property (@(posedge clk) disable iff (!rstN)
    mReq |-> ((mAddr & ADDR_W'((32'd1 << mSize) - 32'd1)) == '0));

  // R4: a write-back only follows a clean backing read
  a_r4_read_first: assert property (@(posedge clk) disable iff (!rstN)
    (mReq && mWrite && !$past(mReq && mWrite)) |->
      $past(mReq && !mWrite && mAck && !mErr));

  // R5: read error ends the operation without write-back
  a_r5_abort: assert property (@(posedge clk) disable iff (!rstN)
    (mReq && !mWrite && mAck && mErr) |=> (!mReq && sDone && sErr));

  // R6: write-back status reaches the requester
  a_r6_wr_err: assert property (@(posedge clk) disable iff (!rstN)
    (mReq && mWrite && mAck) |=> (sDone && (sErr == $past(mErr))));

  // R7: busy after acceptance
  a_r7_busy: assert property (@(posedge clk) disable iff (!rstN)
    (sValid && sReady) |=> !sReady);

  // R8: request held stable until acknowledged
  a_r8_hold: assert property (@(posedge clk) disable iff (!rstN)
    (mReq && !mAck) |=> (mReq && $stable(mAddr) && $stable(mSize) && $stable(mWrite)));

  // R9: single-cycle completion, then idle
  a_r9_pulse: assert property (@(posedge clk) disable iff (!rstN)
    sDone |=> (!sDone && sReady));

endmodule

bind bitband_bridge bitband_bridge_chk #(
  .ADDR_W (ADDR_W),
  .DATA_W (DATA_W)
) u_chk (
  .clk    (clk),
  .rstN   (rstN),
  .sValid (sValid),
  .sReady (sReady),
  .sDone  (sDone),
  .sErr   (sErr),
  .mReq   (mReq),
  .mWrite (mWrite),
  .mAddr  (mAddr),
  .mSize  (mSize),
  .mAck   (mAck),
  .mErr   (mErr)
);

// File: tb/bitband_bridge_bench.sv
module bitband_bridge_bench;

  localparam logic [31:0] BASE = 32'h2000_0000;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        sValid = 1'b0, sWrite = 1'b0, sWbit = 1'b0;
  logic [24:0] sAddr = '0;
  logic [1:0]  sSize = '0;
  logic        sReady, sDone, sErr;
  logic [31:0] sRdata;
  logic        mReq, mWrite;
  logic [31:0] mAddr, mWdata;
  logic [1:0]  mSize;
  logic        mAck = 1'b0, mErr = 1'b0;
  logic [31:0] mRdata = '0;

  always #2.5 clk = ~clk;

  bitband_bridge #(.BASE(BASE)) u_bitband_bridge (
    .clk(clk), .rstN(rstN),
    .sValid(sValid), .sReady(sReady), .sWrite(sWrite), .sAddr(sAddr),
    .sSize(sSize), .sWbit(sWbit), .sDone(sDone), .sRdata(sRdata), .sErr(sErr),
    .mReq(mReq), .mWrite(mWrite), .mAddr(mAddr), .mSize(mSize), .mWdata(mWdata),
    .mAck(mAck), .mRdata(mRdata), .mErr(mErr)
  );

  int checks = 0, fails = 0;
  logic [7:0] mem [256];
  logic [7:0] refMem [256];

  // memory controls and reference expectations
  int          lat = 0;
  bit          errRd = 0, errWr = 0;
  logic [31:0] expAddr = '0, expWdata = '0;
  logic [1:0]  expSize = '0;
  bit          expWrOk = 0;
  int          latCnt = 0;

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // backing memory model with latency and error injection
  always @(posedge clk) begin
    if (!rstN) begin
      mAck <= 1'b0; mErr <= 1'b0; latCnt <= 0;
    end else if (mReq && !mAck) begin
      if (latCnt >= lat) begin
        logic [31:0] rv;
        rv = '0;
        latCnt <= 0;
        mAck <= 1'b1;
        if (!mWrite) begin
          for (int k = 0; k < 4; k++)
            if (k < (1 << mSize)) rv[8*k +: 8] = mem[(mAddr[7:0] + k) & 8'hFF];
          mRdata <= rv;
          mErr <= errRd;
        end else begin
          mErr <= errWr;
          if (!errWr)
            for (int k = 0; k < 4; k++)
              if (k < (1 << mSize)) mem[(mAddr[7:0] + k) & 8'hFF] <= mWdata[8*k +: 8];
        end
      end else latCnt <= latCnt + 1;
    end else begin
      mAck <= 1'b0; mErr <= 1'b0;
    end
  end

  // per-clock comparison of the master port with the reference
  always @(negedge clk) begin
    if (rstN && mReq) begin
      check(mAddr == expAddr && mSize == expSize, "R2 R8 master address/size", mAddr, expAddr);
      if (mWrite) begin
        check(expWrOk, "R5 unexpected write-back", 32'(mWrite), 32'd0);
        if (expWrOk) check(mWdata == expWdata, "R4 write-back data", mWdata, expWdata);
      end
    end
  end

  task automatic op(input bit wr, input int off, input int sz, input bit wb,
                    input int lt, input bit eR, input bit eW, input string tag);
    int nb, idx, cyc;
    logic [31:0] a, old, nw;
    bit expBit, expErr;
    nb = 1 << sz;
    a = (BASE | 32'(off >> 5)) & ~32'(nb - 1);
    idx = (off >> 2) & (8 * nb - 1);
    old = '0;
    for (int k = 0; k < nb; k++) old[8*k +: 8] = refMem[(a[7:0] + k) & 8'hFF];
    expBit = old[idx];
    nw = old; nw[idx] = wb;
    expAddr = a; expSize = 2'(sz); expWdata = nw;
    expWrOk = wr && !eR;
    expErr = eR || (wr && eW);
    lat = lt; errRd = eR; errWr = eW;
    @(negedge clk);
    while (!sReady) @(negedge clk);
    sValid = 1'b1; sWrite = wr; sAddr = 25'(off); sSize = 2'(sz); sWbit = wb;
    @(negedge clk);
    sValid = 1'b0;
    cyc = 0;
    while (!sDone && cyc < 200) begin
      if (sReady) check(1'b0, {"R7 ready while busy ", tag}, 32'd1, 32'd0);
      @(negedge clk); cyc++;
    end
    check(sDone, {"R9 completion ", tag}, 32'(sDone), 32'd1);
    check(sErr == expErr, {"R5 R6 error status ", tag}, 32'(sErr), 32'(expErr));
    check(sRdata == ((!wr && !eR) ? 32'(expBit) : 32'd0), {"R3 read result ", tag},
          sRdata, (!wr && !eR) ? 32'(expBit) : 32'd0);
    if (wr && !eR && !eW)
      for (int k = 0; k < nb; k++) refMem[(a[7:0] + k) & 8'hFF] = nw[8*k +: 8];
    @(negedge clk);
    check(!sDone && sReady, {"R9 single pulse ", tag}, 32'(sDone), 32'd0);
    begin
      int bad = 0;
      for (int i = 0; i < 256; i++) if (mem[i] !== refMem[i]) bad++;
      check(bad == 0, {"R4 backing memory image ", tag}, 32'(bad), 32'd0);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    check(1'b0, "watchdog", 32'd1, 32'd0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) begin
      mem[i] = 8'((i * 37 + 5) & 255);
      refMem[i] = mem[i];
    end
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(sReady && !sDone && !mReq, "R1 reset state", {sReady, sDone, mReq}, 32'b100);

    // reads: byte, half with upper-byte bit, word bit 31 (R3, R2)
    op(0, (8'h10 << 5) | (3 << 2), 0, 0, 0, 0, 0, "R3 byte read");
    op(0, (8'h11 << 5) | (5 << 2), 0, 0, 2, 0, 0, "R3 byte read b5");
    op(0, (8'h21 << 5) | (6 << 2), 1, 0, 1, 0, 0, "R3 half upper byte");
    op(0, (8'h43 << 5) | (7 << 2), 2, 0, 3, 0, 0, "R3 word bit31");
    op(0, (8'h40 << 5), 2, 0, 0, 0, 0, "R3 word bit0");
    // writes: set, clear, word with unaligned-looking offset (R4, R2)
    op(1, (8'h30 << 5) | (2 << 2), 0, 1, 0, 0, 0, "R4 byte set");
    op(1, (8'h31 << 5) | (0 << 2), 0, 0, 1, 0, 0, "R4 byte clear");
    op(1, (8'h53 << 5) | (4 << 2), 1, 1, 2, 0, 0, "R2 half rounded");
    op(1, (8'h67 << 5) | (7 << 2), 2, 0, 0, 0, 0, "R4 word clear bit31");
    op(1, (8'h67 << 5) | (7 << 2), 2, 1, 4, 0, 0, "R4 word set bit31");
    op(0, (8'h67 << 5) | (7 << 2), 2, 0, 0, 0, 0, "R3 readback");
    // errors (R5, R6)
    op(0, (8'h70 << 5) | (1 << 2), 0, 0, 1, 1, 0, "R5 read error");
    op(1, (8'h71 << 5) | (1 << 2), 0, 1, 2, 1, 0, "R5 write read-error");
    op(1, (8'h72 << 5) | (6 << 2), 1, 1, 1, 0, 1, "R6 write-back error");
    op(1, (8'h73 << 5) | (6 << 2), 0, 1, 0, 0, 0, "R6 clean write");
    // R7: conflicting request presented while busy
    fork
      op(1, (8'h80 << 5) | (3 << 2), 0, 1, 6, 0, 0, "R7 busy op");
      begin
        repeat (3) @(negedge clk);
        sValid = 1'b1; sWrite = 1'b1; sAddr = 25'((8'h90 << 5) | (1 << 2));
        sSize = 2'd0; sWbit = ~mem[8'h90][1];
        repeat (3) @(negedge clk);
        sValid = 1'b0;
      end
    join
    check(mem[8'h90] == refMem[8'h90], "R7 busy request ignored", 32'(mem[8'h90]), 32'(refMem[8'h90]));
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule